// File: doc/BRIEF.md
# Scan chain update controller

This block drives a serial scan chain that runs past several small user designs on one die. Each design owns one slot of `SLOT_BITS` scan flops. The flops are loaded from the chain when a shift clock is pulsed with select low. They are loaded from the design outputs when the same clock is pulsed with select high. A latch pulse copies every slot onto its design's inputs.

A host supplies a slot index, a byte and a wait-state count, then raises `start` for one cycle. The controller runs the whole sequence on its own:
- It rotates the byte into the chosen slot.
- It pulses the latch so the design sees the byte.
- It raises select and gives one capture clock, which loads the design outputs into the chain.
- It rotates the full chain back past the return input and picks out the chosen slot's byte.
- It presents that byte on `rd_data` with a one-cycle `done` pulse.

Every change of a chain control line is separated by a programmable number of system clocks. This keeps a long chain free of hold problems.

Top module: `scan_update_ctrl`

## Requirements
- R1: While `rst_n` is low, `sc_clk`, `sc_tx`, `sc_sel`, `sc_latch`, `done` and `rd_data` are all 0.
- R2: The load phase shifts exactly CHAIN_BITS = NUM_SLOTS*SLOT_BITS bits. The chain flop nearest the controller has index 0, and slot N covers indices N*SLOT_BITS to N*SLOT_BITS+SLOT_BITS-1, with bit b of the byte at index N*SLOT_BITS+b. The byte is sent most significant bit first, at shift positions CHAIN_BITS-SLOT_BITS*(N+1) onward. `sc_tx` changes only while `sc_clk` is low.
- R3: Each shifted bit gets one full `sc_clk` period: data set, clock rise, clock fall. `sc_sel` stays low for the whole load and readback.
- R4: After the load, `sc_latch` is pulsed high once, with `sc_clk` and `sc_sel` low.
- R5: After the latch, `sc_sel` goes high, one capture clock pulse is given, and `sc_sel` returns low. `sc_sel` never changes while `sc_clk` is high.
- R6: Consecutive control changes are `wait_cfg`+1 system clocks apart. `wait_cfg` is sampled only when a start is accepted, so changing it mid-run has no effect. A run therefore lasts 1+(6*CHAIN_BITS+6)*(W+1) cycles from acceptance to `done`.
- R7: The readback shifts CHAIN_BITS bits and samples `sc_rx` before each rising clock. The sample at shift position i becomes bit CHAIN_BITS-1-SLOT_BITS*N-i of `rd_data`.
- R8: `done` is high for exactly one cycle per accepted run, and `rd_data` changes only on that cycle.
- R9: A `start` received while a run is in progress is ignored. Its slot, byte and wait count have no effect.
- R10: A `start` whose `slot_idx` is NUM_SLOTS or more is ignored: the chain lines stay idle and no `done` follows.
- R11: With FILL_RECIRC=1 (the default), every bit sent outside the target window is the bit arriving on `sc_rx` at that moment. The rest of the chain is therefore rotated back into place, and a zero is sent after the last readback bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run an update |
| slot_idx | input | IDX_W | Target slot, 0-based |
| wr_data | input | SLOT_BITS | Byte applied to the target design |
| wait_cfg | input | WAIT_W | Extra system clocks between control changes |
| done | output | 1 | One-cycle pulse when `rd_data` is fresh |
| rd_data | output | SLOT_BITS | Byte captured from the target design |
| sc_clk | output | 1 | Chain shift clock |
| sc_tx | output | 1 | Serial data into the chain |
| sc_sel | output | 1 | Chain flop source: 0 chain, 1 design outputs |
| sc_latch | output | 1 | Copies chain contents onto design inputs |
| sc_rx | input | 1 | Serial data returning from the chain end |

## Verification
The bench models the chain and a row of inverting designs, and it predicts every control line cycle by cycle from the requirements. It goes after the following corner cases:
- The first and last slot: an off-by-one window would leave the byte straddling two slots and return a wrong `rd_data`.
- A zero wait count, and a wait count changed mid-run: a design that re-reads the count would shift its edges and its `done` cycle.
- A start during a run: a design that accepted it would reload the slot or emit a second `done`.
- Out-of-range indices: a design without the range check would start toggling the chain.
- Untouched slots, checked against their previously captured values: a design that zero-filled or misaligned the rotation would corrupt them.

// File: rtl/scanctl_pkg.sv
package scanctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SI_DATA,
    ST_SI_RISE,
    ST_SI_FALL,
    ST_LAT_ON,
    ST_LAT_OFF,
    ST_CAP_SEL,
    ST_CAP_RISE,
    ST_CAP_FALL,
    ST_CAP_DESEL,
    ST_SO_DATA,
    ST_SO_RISE,
    ST_SO_FALL,
    ST_FIN
  } seq_state_e;

  // First shift position of the target slot's window.
  function automatic int unsigned win_first(input int unsigned chain_bits,
                                            input int unsigned slot_bits,
                                            input int unsigned slot);
    return chain_bits - slot_bits * (slot + 1);
  endfunction

  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned first,
                                     input int unsigned slot_bits);
    return (pos >= first) && (pos < first + slot_bits);
  endfunction

  // Byte bit carried at shift position pos (most significant bit first).
  function automatic int unsigned msb_first_index(input int unsigned pos,
                                                  input int unsigned first,
                                                  input int unsigned slot_bits);
    return slot_bits - 1 - (pos - first);
  endfunction

endpackage

// File: rtl/scanctl_pacer.sv
module scanctl_pacer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              run,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              tick
);

  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      cnt_q  <= '0;
    end else if (arm) begin
      wait_q <= wait_in;
      cnt_q  <= '0;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= wait_q;
      else             cnt_q <= cnt_q - WAIT_W'(1);
    end
  end

  assign tick = run && (cnt_q == '0);

  // R6
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (wait_q != '0)) |=> !tick)
    else $error("control events closer than the wait count");

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(wait_q))
    else $error("wait count changed outside acceptance");

endmodule

// File: rtl/scanctl_payload.sv
module scanctl_payload
  import scanctl_pkg::*;
#(
  parameter int  NUM_SLOTS   = 6,
  parameter int  SLOT_BITS   = 8,
  parameter bit  FILL_RECIRC = 1'b1,
  localparam int CHAIN_BITS  = NUM_SLOTS * SLOT_BITS,
  localparam int IDX_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W       = (CHAIN_BITS > 1) ? $clog2(CHAIN_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [IDX_W-1:0]     slot_in,
  input  logic [SLOT_BITS-1:0] data_in,
  input  logic                 grab,
  input  logic                 commit,
  input  logic [CNT_W-1:0]     bit_pos,
  input  logic                 chain_rx,
  output logic                 si_bit,
  output logic                 so_bit,
  output logic [SLOT_BITS-1:0] rd_data
);

  logic [IDX_W-1:0]     slot_q;
  logic [SLOT_BITS-1:0] data_q;
  logic [SLOT_BITS-1:0] byte_q;
  logic [SLOT_BITS-1:0] rd_q;
  logic [SLOT_BITS-1:0] shifted;
  int unsigned          first_pos;
  int unsigned          pick_idx;
  logic                 hit;
  logic                 fill;

  assign first_pos = win_first(CHAIN_BITS, SLOT_BITS, 32'(slot_q));
  assign hit       = in_window(32'(bit_pos), first_pos, SLOT_BITS);
  assign pick_idx  = msb_first_index(32'(bit_pos), first_pos, SLOT_BITS);
  assign shifted   = data_q >> pick_idx;

  generate
    if (FILL_RECIRC) begin : g_recirc
      assign fill = chain_rx;
    end else begin : g_zero
      assign fill = 1'b0;
    end
  endgenerate

  assign si_bit  = hit ? shifted[0] : fill;
  assign so_bit  = fill;
  assign rd_data = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      data_q <= '0;
      byte_q <= '0;
      rd_q   <= '0;
    end else begin
      if (arm) begin
        slot_q <= slot_in;
        data_q <= data_in;
        byte_q <= '0;
      end else if (grab && hit) begin
        byte_q <= {byte_q[SLOT_BITS-2:0], chain_rx};
      end
      if (commit) rd_q <= byte_q;
    end
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rd_q))
    else $error("read byte moved without a commit");

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ($stable(slot_q) && $stable(data_q)))
    else $error("request fields changed outside acceptance");

endmodule

// File: rtl/scanctl_seq.sv
module scanctl_seq
  import scanctl_pkg::*;
#(
  parameter int  CHAIN_BITS = 48,
  localparam int CNT_W      = (CHAIN_BITS > 1) ? $clog2(CHAIN_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             slot_ok,
  input  logic             tick,
  input  logic             si_bit,
  input  logic             so_bit,
  output logic             arm,
  output logic             run,
  output logic             grab,
  output logic             commit,
  output logic [CNT_W-1:0] bit_pos,
  output logic             sc_clk,
  output logic             sc_tx,
  output logic             sc_sel,
  output logic             sc_latch,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CHAIN_BITS - 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clk_q, tx_q, sel_q, lat_q, done_q;
  logic             last_bit;

  assign arm      = (st_q == ST_IDLE) && start && slot_ok;
  assign run      = (st_q != ST_IDLE);
  assign grab     = tick && (st_q == ST_SO_DATA);
  assign commit   = tick && (st_q == ST_FIN);
  assign last_bit = (cnt_q == LAST_POS);
  assign bit_pos  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      tx_q   <= 1'b0;
      sel_q  <= 1'b0;
      lat_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (arm) begin
        st_q  <= ST_SI_DATA;
        cnt_q <= '0;
      end else if (tick) begin
        unique case (st_q)
          ST_SI_DATA: begin
            tx_q <= si_bit;
            st_q <= ST_SI_RISE;
          end
          ST_SI_RISE: begin
            clk_q <= 1'b1;
            st_q  <= ST_SI_FALL;
          end
          ST_SI_FALL: begin
            clk_q <= 1'b0;
            if (last_bit) begin
              cnt_q <= '0;
              st_q  <= ST_LAT_ON;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
              st_q  <= ST_SI_DATA;
            end
          end
          ST_LAT_ON: begin
            lat_q <= 1'b1;
            st_q  <= ST_LAT_OFF;
          end
          ST_LAT_OFF: begin
            lat_q <= 1'b0;
            st_q  <= ST_CAP_SEL;
          end
          ST_CAP_SEL: begin
            sel_q <= 1'b1;
            st_q  <= ST_CAP_RISE;
          end
          ST_CAP_RISE: begin
            clk_q <= 1'b1;
            st_q  <= ST_CAP_FALL;
          end
          ST_CAP_FALL: begin
            clk_q <= 1'b0;
            st_q  <= ST_CAP_DESEL;
          end
          ST_CAP_DESEL: begin
            sel_q <= 1'b0;
            st_q  <= ST_SO_DATA;
          end
          ST_SO_DATA: begin
            tx_q <= so_bit;
            st_q <= ST_SO_RISE;
          end
          ST_SO_RISE: begin
            clk_q <= 1'b1;
            st_q  <= ST_SO_FALL;
          end
          ST_SO_FALL: begin
            clk_q <= 1'b0;
            if (last_bit) begin
              st_q <= ST_FIN;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
              st_q  <= ST_SO_DATA;
            end
          end
          ST_FIN: begin
            tx_q <= 1'b0;
            st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sc_clk   = clk_q;
  assign sc_tx    = tx_q;
  assign sc_sel   = sel_q;
  assign sc_latch = lat_q;
  assign done     = done_q;

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |-> $stable(tx_q))
    else $error("serial data moved while the shift clock was high");

  // R4
  latch_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |-> (!clk_q && !sel_q))
    else $error("latch overlapped clock or select");

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q |-> $stable(sel_q))
    else $error("select moved while the shift clock was high");

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done held longer than one cycle");

  // R10
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && start && !slot_ok) |=> (st_q == ST_IDLE))
    else $error("out-of-range slot started a run");

endmodule

// File: rtl/scan_update_ctrl.sv
module scan_update_ctrl
  import scanctl_pkg::*;
#(
  parameter int  NUM_SLOTS   = 6,
  parameter int  SLOT_BITS   = 8,
  parameter int  WAIT_W      = 4,
  parameter bit  FILL_RECIRC = 1'b1,
  localparam int CHAIN_BITS  = NUM_SLOTS * SLOT_BITS,
  localparam int IDX_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W       = (CHAIN_BITS > 1) ? $clog2(CHAIN_BITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IDX_W-1:0]     slot_idx,
  input  logic [SLOT_BITS-1:0] wr_data,
  input  logic [WAIT_W-1:0]    wait_cfg,
  output logic                 done,
  output logic [SLOT_BITS-1:0] rd_data,
  output logic                 sc_clk,
  output logic                 sc_tx,
  output logic                 sc_sel,
  output logic                 sc_latch,
  input  logic                 sc_rx
);

  logic             slot_ok;
  logic             arm, run, tick, grab, commit;
  logic             si_bit, so_bit;
  logic [CNT_W-1:0] bit_pos;

  assign slot_ok = ({1'b0, slot_idx} < NUM_SLOTS[IDX_W:0]);

  scanctl_pacer #(.WAIT_W(WAIT_W)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .run     (run),
    .wait_in (wait_cfg),
    .tick    (tick)
  );

  scanctl_payload #(
    .NUM_SLOTS   (NUM_SLOTS),
    .SLOT_BITS   (SLOT_BITS),
    .FILL_RECIRC (FILL_RECIRC)
  ) u_payload (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .slot_in  (slot_idx),
    .data_in  (wr_data),
    .grab     (grab),
    .commit   (commit),
    .bit_pos  (bit_pos),
    .chain_rx (sc_rx),
    .si_bit   (si_bit),
    .so_bit   (so_bit),
    .rd_data  (rd_data)
  );

  scanctl_seq #(.CHAIN_BITS(CHAIN_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .slot_ok  (slot_ok),
    .tick     (tick),
    .si_bit   (si_bit),
    .so_bit   (so_bit),
    .arm      (arm),
    .run      (run),
    .grab     (grab),
    .commit   (commit),
    .bit_pos  (bit_pos),
    .sc_clk   (sc_clk),
    .sc_tx    (sc_tx),
    .sc_sel   (sc_sel),
    .sc_latch (sc_latch),
    .done     (done)
  );

endmodule

// File: tb/scan_update_ctrl_tb.sv
module scan_update_ctrl_tb;
  localparam int NS = 6;
  localparam int SB = 8;
  localparam int WW = 4;
  localparam int L  = NS * SB;
  localparam int E  = 6 * L + 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] slot = '0;
  logic [SB-1:0] wdata = '0;
  logic [WW-1:0] wcfg = '0;
  logic done, sclk, stx, ssel, slat, srx;
  logic [SB-1:0] rd;

  always #4 clk = ~clk;

  scan_update_ctrl #(.NUM_SLOTS(NS), .SLOT_BITS(SB), .WAIT_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_idx(slot), .wr_data(wdata),
    .wait_cfg(wcfg), .done(done), .rd_data(rd), .sc_clk(sclk), .sc_tx(stx),
    .sc_sel(ssel), .sc_latch(slat), .sc_rx(srx));

  // Environment: chain of flops plus one inverting design per slot.
  logic [L-1:0] chain = '0;
  logic [SB-1:0] din [NS];
  logic [SB-1:0] expc [NS];
  initial for (int k = 0; k < NS; k++) begin din[k] = '0; expc[k] = '0; end
  assign srx = chain[L-1];

  int n_sclk = 0;
  always @(posedge sclk) begin
    n_sclk++;
    if (ssel) for (int k = 0; k < NS; k++) chain[k*SB +: SB] <= ~din[k];
    else chain <= {chain[L-2:0], stx};
  end
  always @(posedge slat) for (int k = 0; k < NS; k++) din[k] <= chain[k*SB +: SB];

  // Reference model
  typedef struct packed { logic c, t, s, l, f; logic [SB-1:0] r; } ev_t;
  ev_t q[$];
  int gap = 0, w_run = 0, cyc = 0, acc_cyc = 0, done_cyc = 0, n_done = 0;
  bit busy_m = 0, skip = 0;
  logic e_c = 0, e_t = 0, e_s = 0, e_l = 0, e_d = 0;
  logic [SB-1:0] e_r = '0;
  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic build(input int n, input logic [SB-1:0] d);
    logic [L-1:0] m = chain;
    logic [SB-1:0] dm [NS];
    logic [SB-1:0] acc = '0;
    logic b = 1'b0;
    int first = L - SB * (n + 1);
    for (int k = 0; k < NS; k++) dm[k] = din[k];
    for (int i = 0; i < L; i++) begin
      b = (i >= first && i < first + SB) ? d[SB-1-(i-first)] : m[L-1];
      q.push_back('{1'b0, b, 1'b0, 1'b0, 1'b0, '0});
      q.push_back('{1'b1, b, 1'b0, 1'b0, 1'b0, '0});
      m = {m[L-2:0], b};
      q.push_back('{1'b0, b, 1'b0, 1'b0, 1'b0, '0});
    end
    for (int k = 0; k < NS; k++) dm[k] = m[k*SB +: SB];
    q.push_back('{1'b0, b, 1'b0, 1'b1, 1'b0, '0});
    q.push_back('{1'b0, b, 1'b0, 1'b0, 1'b0, '0});
    q.push_back('{1'b0, b, 1'b1, 1'b0, 1'b0, '0});
    q.push_back('{1'b1, b, 1'b1, 1'b0, 1'b0, '0});
    for (int k = 0; k < NS; k++) m[k*SB +: SB] = ~dm[k];
    q.push_back('{1'b0, b, 1'b1, 1'b0, 1'b0, '0});
    q.push_back('{1'b0, b, 1'b0, 1'b0, 1'b0, '0});
    for (int i = 0; i < L; i++) begin
      b = m[L-1];
      if (i >= first && i < first + SB) acc = {acc[SB-2:0], b};
      q.push_back('{1'b0, b, 1'b0, 1'b0, 1'b0, '0});
      q.push_back('{1'b1, b, 1'b0, 1'b0, 1'b0, '0});
      m = {m[L-2:0], b};
      q.push_back('{1'b0, b, 1'b0, 1'b0, 1'b0, '0});
    end
    q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, acc});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n && !busy_m && start && (int'(slot) < NS)) begin
      build(int'(slot), wdata);
      busy_m = 1; skip = 1; gap = 0; w_run = int'(wcfg); acc_cyc = cyc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      ev_t ev;
      if (skip) begin
        skip = 0; e_d = 0;
      end else if (gap == 0 && q.size() > 0) begin
        ev = q.pop_front();
        e_c = ev.c; e_t = ev.t; e_s = ev.s; e_l = ev.l; e_d = ev.f;
        if (ev.f) begin e_r = ev.r; busy_m = 0; end
        gap = w_run;
      end else begin
        e_d = 0;
        if (gap > 0) gap--;
      end
      if (done) begin n_done++; done_cyc = cyc; end
      n_tests++;
      if (sclk !== e_c || stx !== e_t || ssel !== e_s || slat !== e_l ||
          done !== e_d || rd !== e_r) begin
        n_fail++;
        if (sclk !== e_c) $display("FAIL R3 sc_clk cycle %0d: actual=%b expected=%b", cyc, sclk, e_c);
        if (stx !== e_t)  $display("FAIL R2 sc_tx cycle %0d: actual=%b expected=%b", cyc, stx, e_t);
        if (ssel !== e_s) $display("FAIL R5 sc_sel cycle %0d: actual=%b expected=%b", cyc, ssel, e_s);
        if (slat !== e_l) $display("FAIL R4 sc_latch cycle %0d: actual=%b expected=%b", cyc, slat, e_l);
        if (done !== e_d) $display("FAIL R8 done cycle %0d: actual=%b expected=%b", cyc, done, e_d);
        if (rd !== e_r)   $display("FAIL R7 rd_data cycle %0d: actual=%h expected=%h", cyc, rd, e_r);
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 20000 && (busy_m || q.size() > 0); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(input int n, input logic [SB-1:0] d, input int w,
                    input int w_after, input bit interrupt);
    int d0 = n_done;
    @(negedge clk);
    slot = 3'(n); wdata = d; wcfg = WW'(w); start = 1'b1;
    @(negedge clk);
    start = 1'b0; wcfg = WW'(w_after);
    if (interrupt) begin
      repeat (40) @(negedge clk);
      slot = 3'((n + 1) % NS); wdata = ~d; wcfg = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
    chk(din[n] == d, "R2", "byte in target slot", 32'(din[n]), 32'(d));
    chk(rd == ~d, "R7", "read-back byte", 32'(rd), 32'(~d));
    chk(n_done - d0 == 1, "R8", "done pulses per run", 32'(n_done - d0), 32'd1);
    chk(done_cyc - acc_cyc == 1 + (E - 1) * (w + 1), "R6", "run length",
        32'(done_cyc - acc_cyc), 32'(1 + (E - 1) * (w + 1)));
    for (int k = 0; k < NS; k++)
      if (k != n) chk(din[k] == expc[k], "R11", "untouched slot rotated back",
                      32'(din[k]), 32'(expc[k]));
    if (interrupt) chk(din[(n+1)%NS] != ~d || expc[(n+1)%NS] == ~d, "R9",
                       "ignored start left neighbour alone", 32'(din[(n+1)%NS]), 32'(expc[(n+1)%NS]));
    for (int k = 0; k < NS; k++) expc[k] = ~din[k];
  endtask

  task automatic bad_slot(input logic [2:0] s);
    int c0 = n_sclk, d0 = n_done;
    @(negedge clk);
    slot = s; wdata = 8'h5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_sclk == c0 && !busy_m, "R10", "clock edges after bad index", 32'(n_sclk - c0), 32'd0);
    chk(n_done == d0, "R10", "done after bad index", 32'(n_done - d0), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog R6: actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk({sclk, stx, ssel, slat, done} == 5'b0 && rd == '0, "R1", "outputs in reset",
        {24'b0, 3'b0, sclk, stx, ssel, slat, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    op(2, 8'h02, 1, 1, 1'b0);
    op(0, 8'hA5, 0, 0, 1'b0);
    op(NS - 1, 8'h3C, 3, 0, 1'b0);  // R6: wait count changed mid-run
    op(3, 8'hFF, 2, 2, 1'b1);       // R9: start during run
    bad_slot(3'd6);
    bad_slot(3'd7);
    op(1, 8'h00, 0, 5, 1'b0);
    op(4, 8'h81, 1, 1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule